// File: doc/BRIEF.md
# Key-Gated Clock Configuration Register Window

This block holds the clock configuration fields of a chip behind a byte-wide register bus. It covers oscillator source selection, oscillator power-down, the PLL feedback divider and the output divider. These fields can change only while a write window is open. Software opens the window by writing an unlock key to the key register. The window then stays open for a fixed number of clock cycles, or until software writes a lock key.

The other fields in the same registers are unprotected, and they accept writes at all times. Examples are the trim bit, the VCO bypass, the oscillator disconnect and the relock request. Reads are combinational. The key register reads back a status bit that shows whether the window is open. The PLL register reads back the lock indication supplied by the clock hardware.

Top module: `keygate_clk_regs`

## Requirements
- R1: After reset the window is closed (key register bit 0 reads 0). The oscillator register (address 1) reads 0x10, the PLL register (address 2) reads 0x04 plus the lock input in bit 0, and the divider register (address 3) reads 0x00.
- R2: Writing 0x98 to the key register (address 0) opens the window, and key register bit 0 reads 1 from the next cycle.
- R3: A protected write is accepted on each of the WIN_LEN (32) clock edges that follow the unlock edge, including the last one. A protected write on the edge after that is ignored, and the status bit then reads 0.
- R4: Writing 0xAB to the key register closes the window at once. A protected write on the next edge is ignored.
- R5: Any other key value leaves the window state unchanged, whether the window is open or closed.
- R6: While the window is closed, protected bits keep their value and unprotected bits in the same write update normally. The protected bits are oscillator register bits 4 and 1:0, PLL register bits 7:4 and divider register bits 5:4.
- R7: An unlock write made while the window is open restarts the full WIN_LEN window from that write.
- R8: The PLL register layout is fixed: feedback divider in bits 7:4, VCO bypass in bit 3, oscillator disconnect in bit 2, relock request in bit 1 and lock status in bit 0. Oscillator register bits 6:5 read 0 and bits 1:0 select the source.
- R9: Writing 1 to PLL register bit 1 produces a one-cycle relock pulse, whatever the window state. That bit always reads 0, and bit 0 always reflects the lock input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| pll_lock_in | input | 1 | Lock indication from the PLL |
| win_open | output | 1 | Protected window open |
| osc_src | output | 2 | Oscillator source select |
| osc_pd | output | 1 | Oscillator power-down |
| osc_disc | output | 1 | Oscillator disconnect |
| pll_ndiv | output | 4 | PLL feedback divider |
| pll_bypass | output | 1 | VCO bypass |
| out_div | output | 2 | Output divider |
| relock | output | 1 | One-cycle lock-detect restart pulse |

## Verification
The writes with all bits set are applied in both window states. This separates the protected bits from the unprotected bits of each register. Protected writes placed exactly on the 32nd and 33rd edge after an unlock pin down the window length with no off-by-one slack. A second unlock partway through the window checks that the count restarts rather than extends. Neutral key values, sent in each state, show that only the two keys change the state.

// File: rtl/keygate_clk_regs.sv
module keygate_clk_regs #(
  parameter int WIN_LEN  = 32,
  parameter logic [7:0] KEY_OPEN = 8'h98,
  parameter logic [7:0] KEY_SHUT = 8'hAB
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       pll_lock_in,
  output logic       win_open,
  output logic [1:0] osc_src,
  output logic       osc_pd,
  output logic       osc_disc,
  output logic [3:0] pll_ndiv,
  output logic       pll_bypass,
  output logic [1:0] out_div,
  output logic       relock
);
  localparam int CW = $clog2(WIN_LEN + 1);
  localparam logic [CW-1:0] WIN_INIT = CW'(WIN_LEN);
  localparam logic [1:0] A_KEY = 2'd0, A_OSC = 2'd1, A_PLL = 2'd2, A_DIV = 2'd3;
  localparam logic [7:0] OSC_WR = 8'h9F, OSC_PROT = 8'h13, OSC_RST = 8'h10;
  localparam logic [7:0] PLL_WR = 8'hFC, PLL_PROT = 8'hF0, PLL_RST = 8'h04;
  localparam logic [7:0] DIV_WR = 8'hFF, DIV_PROT = 8'h30, DIV_RST = 8'h00;

  logic [CW-1:0] cnt_q;
  logic [7:0] osc_q, pll_q, div_q;

  wire key_wr  = wr_en && addr == A_KEY;
  wire do_open = key_wr && wdata == KEY_OPEN;
  wire do_shut = key_wr && wdata == KEY_SHUT;

  assign win_open = cnt_q != '0;

  wire [7:0] osc_m = OSC_WR & (win_open ? 8'hFF : ~OSC_PROT);
  wire [7:0] pll_m = PLL_WR & (win_open ? 8'hFF : ~PLL_PROT);
  wire [7:0] div_m = DIV_WR & (win_open ? 8'hFF : ~DIV_PROT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (do_open) cnt_q <= WIN_INIT;
    else if (do_shut) cnt_q <= '0;
    else if (win_open) cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q  <= OSC_RST;
      pll_q  <= PLL_RST;
      div_q  <= DIV_RST;
      relock <= 1'b0;
    end else begin
      relock <= wr_en && addr == A_PLL && wdata[1];
      if (wr_en && addr == A_OSC) osc_q <= (osc_q & ~osc_m) | (wdata & osc_m);
      if (wr_en && addr == A_PLL) pll_q <= (pll_q & ~pll_m) | (wdata & pll_m);
      if (wr_en && addr == A_DIV) div_q <= (div_q & ~div_m) | (wdata & div_m);
    end
  end

  assign osc_src    = osc_q[1:0];
  assign osc_pd     = osc_q[4];
  assign pll_ndiv   = pll_q[7:4];
  assign pll_bypass = pll_q[3];
  assign osc_disc   = pll_q[2];
  assign out_div    = div_q[5:4];

  always_comb begin
    case (addr)
      A_KEY:   rdata = {7'b0, win_open};
      A_OSC:   rdata = osc_q;
      A_PLL:   rdata = {pll_q[7:2], 1'b0, pll_lock_in};
      default: rdata = div_q;
    endcase
  end

  assert_unlock_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    do_open |=> win_open);
  assert_lock_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    do_shut |=> !win_open);
  assert_stay_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open && !do_open) |=> !win_open);
  assert_ndiv_guarded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> $stable(pll_ndiv));
  assert_src_guarded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> ($stable(osc_src) && $stable(osc_pd) && $stable(out_div)));
  assert_relock_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    relock |=> !relock || $past(wr_en));
endmodule

// File: tb/keygate_clk_regs_bench.sv
module keygate_clk_regs_bench;
  localparam time PERIOD = 10;
  logic clk = 0, rst_n = 0, wr_en = 0, pll_lock_in = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic win_open, osc_pd, osc_disc, pll_bypass, relock;
  logic [1:0] osc_src, out_div;
  logic [3:0] pll_ndiv;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  keygate_clk_regs u_keygate_clk_regs (.*);

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, string req, logic [7:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd(0, "R1 status", 8'h00);
    rd(1, "R1 osc", 8'h10);
    rd(2, "R1 pll", 8'h04);
    rd(3, "R1 div", 8'h00);
  endtask

  task automatic t_locked_write;
    wr(1, 8'hFF); rd(1, "R6 osc locked", 8'h9C);
    wr(2, 8'hFC); rd(2, "R6 pll locked", 8'h0C);
    wr(3, 8'hFF); rd(3, "R6 div locked", 8'hCF);
    chk("R6 src port", {6'b0, osc_src}, 8'h00);
  endtask

  task automatic t_unlock;
    wr(0, 8'h98); rd(0, "R2 status open", 8'h01);
    wr(2, 8'hA0); rd(2, "R8 pll layout", 8'hA0);
    chk("R8 ndiv", {4'b0, pll_ndiv}, 8'h0A);
    chk("R8 disc", {7'b0, osc_disc}, 8'h00);
    pll_lock_in = 1; rd(2, "R9 lock bit", 8'hA1); pll_lock_in = 0;
    wr(1, 8'h02); rd(1, "R8 osc src", 8'h02);
  endtask

  task automatic t_window_edge;
    wr(0, 8'hAB);
    wr(0, 8'h98); idle(31);
    wr(3, 8'h20); chk("R3 last cycle accepted", {6'b0, out_div}, 8'h02);
    rd(0, "R3 closed after window", 8'h00);
    wr(0, 8'h98); idle(32);
    wr(3, 8'h10); chk("R3 after window ignored", {6'b0, out_div}, 8'h02);
  endtask

  task automatic t_lock;
    wr(0, 8'h98); wr(0, 8'hAB);
    rd(0, "R4 status closed", 8'h00);
    wr(1, 8'h00); rd(1, "R4 protected ignored", 8'h02);
  endtask

  task automatic t_other_key;
    wr(0, 8'h55); rd(0, "R5 closed kept", 8'h00);
    wr(2, 8'h50); chk("R5 ndiv kept", {4'b0, pll_ndiv}, 8'h0A);
    wr(0, 8'h98); wr(0, 8'h55); rd(0, "R5 open kept", 8'h01);
    wr(2, 8'h50); chk("R5 ndiv written", {4'b0, pll_ndiv}, 8'h05);
    wr(0, 8'hAB);
  endtask

  task automatic t_restart;
    wr(0, 8'h98); idle(20);
    wr(0, 8'h98); idle(31);
    wr(1, 8'h11); chk("R7 restarted window", {6'b0, osc_src}, 8'h01);
    rd(0, "R7 closed at end", 8'h00);
  endtask

  task automatic t_relock;
    wr(2, 8'h02);
    chk("R9 pulse high", {7'b0, relock}, 8'h01);
    idle(1);
    chk("R9 pulse low", {7'b0, relock}, 8'h00);
    rd(2, "R9 bit1 reads 0", 8'h50);
  endtask

  initial begin
    idle(2); rst_n = 1; idle(1);
    t_reset(); t_locked_write(); t_unlock(); t_window_edge();
    t_lock(); t_other_key(); t_restart(); t_relock();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule